// File: doc/BRIEF.md
# Configuration Cycle Routing Decoder

This block sits on the upstream side of a bus-to-bus bridge. It looks at the address word of each incoming type 1 configuration access and decides how to route it. Three 8-bit registers describe where the bridge sits in the bus tree: its primary bus, its secondary (directly attached downstream) bus, and its subordinate (highest-numbered downstream) bus. The block compares the bus number in the address with these registers and picks one of three outcomes:

- **Not claimed.** The access is left alone.
- **Claimed and converted.** The access targets the secondary bus itself. It is rewritten as a type 0 access and one upper address line is driven as the device select (IDSEL).
- **Claimed and forwarded.** The access targets a bus further down. It is passed on unchanged as type 1.

Host software programs the three registers through a small write/read port. The routing result appears on registered outputs one clock after the request strobe.

Top module: `cfg_route_decoder`

## Requirements
- R1: After reset, all three bus number registers read 00h, and `rsp_valid` and `rsp_claim` are 0.
- R2: A write with `reg_wr_en` high updates the primary, secondary or subordinate register when `reg_addr` is 18h, 19h or 1Ah respectively. `reg_rdata` shows the register selected by `reg_addr` in the same cycle. Other offsets read 00h, and writes to them change nothing.
- R3: A request is treated as type 1 only when `req_addr[1:0]` is 01. Any other encoding gives `rsp_claim` = 0.
- R4: A type 1 request whose bus field `req_addr[23:16]` equals the secondary register is claimed with `rsp_type` = 0 (type 0). This holds even when the subordinate register is below the secondary register.
- R5: In a converted address, bits 1:0 are 00 and bits 15:11 are 0. Bits 10:2 carry the function and register fields unchanged. For a device number N = `req_addr[15:11]` below 16, bits 31:16 hold only bit 16+N; `rsp_idsel_vld` is 1 and `rsp_idsel_line` is N.
- R6: A converted request with a device number of 16 or more is still claimed as type 0. Its bits 31:16 are all zero and `rsp_idsel_vld` is 0.
- R7: A type 1 request whose bus field is greater than the secondary register and no greater than the subordinate register is claimed with `rsp_type` = 1. `rsp_addr` equals the request address bit for bit.
- R8: A type 1 request whose bus field is below the secondary register, or above both the secondary and subordinate registers, is not claimed. It gives `rsp_addr` = 0 and `rsp_idsel_vld` = 0.
- R9: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_claim` is 0 whenever `rsp_valid` is 0.
- R10: A request is decoded against the register values held before any register write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address word strobe |
| req_addr | input | 32 | Address phase word of the configuration access |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 8 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rsp_valid | output | 1 | Result valid, one clock after `req_valid` |
| rsp_claim | output | 1 | Access is claimed by the bridge |
| rsp_type | output | 1 | Downstream type: 0 = type 0, 1 = type 1 |
| rsp_addr | output | 32 | Downstream address word |
| rsp_idsel_vld | output | 1 | A device-select line is driven |
| rsp_idsel_line | output | 4 | Index N of the driven line (address line 16+N) |

## Verification
The assertions assume that `req_valid` and `req_addr` are driven to known values from reset onward. They also assume the request address is held stable around the clock edge that captures it, because the forwarding check compares `rsp_addr` with the address sampled one clock earlier.

The bench keeps to these assumptions. It drives every input from time zero, changes inputs only on falling edges, and raises `req_valid` for single-cycle pulses. It issues register writes in separate cycles, except in the one scenario that deliberately overlaps a write with a request.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE    = 2'd0,
    ROUTE_CONVERT = 2'd1,
    ROUTE_FORWARD = 2'd2
  } route_e;

  localparam logic [1:0] TYPE1_ENC   = 2'b01;
  localparam int         FLD_BUS_LSB = 16;
  localparam int         FLD_DEV_LSB = 11;
  localparam int         FLD_DEV_W   = 5;

  localparam logic [7:0] OFS_PRI = 8'h18;
  localparam logic [7:0] OFS_SEC = 8'h19;
  localparam logic [7:0] OFS_SUB = 8'h1A;
endpackage

// File: rtl/cfgr_busregs.sv
module cfgr_busregs #(
  parameter int BUS_W = 8,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] sec_bus,
  output logic [BUS_W-1:0] sub_bus,
  output logic [BUS_W-1:0] rdata
);
  import cfgr_pkg::*;

  logic [BUS_W-1:0] pri_q, sec_q, sub_q;
  logic [BUS_W-1:0] pri_d, sec_d, sub_d;
  logic             hit_pri, hit_sec, hit_sub;

  always_comb begin
    hit_pri = (ofs == OFS_W'(OFS_PRI));
    hit_sec = (ofs == OFS_W'(OFS_SEC));
    hit_sub = (ofs == OFS_W'(OFS_SUB));
  end

  always_comb begin
    pri_d = pri_q;
    sec_d = sec_q;
    sub_d = sub_q;
    if (wr_en && hit_pri) pri_d = wdata;
    if (wr_en && hit_sec) sec_d = wdata;
    if (wr_en && hit_sub) sub_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
      sub_q <= '0;
    end else if (wr_en) begin
      pri_q <= pri_d;
      sec_q <= sec_d;
      sub_q <= sub_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_pri) rdata = pri_q;
    if (hit_sec) rdata = sec_q;
    if (hit_sub) rdata = sub_q;
  end

  assign sec_bus = sec_q;
  assign sub_bus = sub_q;
endmodule

// File: rtl/cfgr_classify.sv
module cfgr_classify #(
  parameter int BUS_W = 8
) (
  input  logic [1:0]       enc,
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output cfgr_pkg::route_e route
);
  import cfgr_pkg::*;

  logic is_t1, eq_sec, in_range;

  always_comb begin
    is_t1    = (enc == TYPE1_ENC);
    eq_sec   = (bus == sec_bus);
    in_range = (bus > sec_bus) && (bus <= sub_bus);
    if (!is_t1)        route = ROUTE_NONE;
    else if (eq_sec)   route = ROUTE_CONVERT;
    else if (in_range) route = ROUTE_FORWARD;
    else               route = ROUTE_NONE;
  end
endmodule

// File: rtl/cfgr_rewrite.sv
module cfgr_rewrite #(
  parameter  int ADDR_W     = 32,
  parameter  int IDSEL_BASE = 16,
  parameter  int DEV_LSB    = 11,
  parameter  int DEV_W      = 5,
  localparam int IDSEL_N    = ADDR_W - IDSEL_BASE,
  localparam int LINE_W     = $clog2(IDSEL_N)
) (
  input  logic [DEV_LSB+DEV_W-1:2] fields,
  output logic [ADDR_W-1:0]        t0_addr,
  output logic                     idsel_vld,
  output logic [LINE_W-1:0]        idsel_line
);
  logic [DEV_W-1:0]   dev;
  logic [IDSEL_N-1:0] line_hit;

  assign dev = fields[DEV_LSB +: DEV_W];

  for (genvar i = 0; i < IDSEL_N; i++) begin : g_line
    assign line_hit[i] = (dev == DEV_W'(i));
  end

  always_comb begin
    t0_addr                          = '0;
    t0_addr[ADDR_W-1:IDSEL_BASE]     = line_hit;
    t0_addr[DEV_LSB-1:2]             = fields[DEV_LSB-1:2];
    idsel_vld                        = |line_hit;
    idsel_line                       = dev[LINE_W-1:0];
  end
endmodule

// File: rtl/cfg_route_decoder.sv
module cfg_route_decoder #(
  parameter  int ADDR_W     = 32,
  parameter  int BUS_W      = 8,
  parameter  int OFS_W      = 8,
  parameter  int IDSEL_BASE = 16,
  localparam int IDSEL_N    = ADDR_W - IDSEL_BASE,
  localparam int LINE_W     = $clog2(IDSEL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              reg_wr_en,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_type,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_idsel_vld,
  output logic [LINE_W-1:0] rsp_idsel_line
);
  import cfgr_pkg::*;

  logic [BUS_W-1:0]  sec_bus, sub_bus;
  route_e            route;
  logic [ADDR_W-1:0] t0_addr;
  logic              t0_idsel_vld;
  logic [LINE_W-1:0] t0_idsel_line;

  logic              valid_q, claim_q, type_q, idsel_vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  logic              claim_d, type_d, idsel_vld_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LINE_W-1:0] line_d;

  cfgr_busregs #(.BUS_W(BUS_W), .OFS_W(OFS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .ofs     (reg_addr),
    .wdata   (reg_wdata),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .rdata   (reg_rdata)
  );

  cfgr_classify #(.BUS_W(BUS_W)) u_cls (
    .enc     (req_addr[1:0]),
    .bus     (req_addr[FLD_BUS_LSB +: BUS_W]),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .route   (route)
  );

  cfgr_rewrite #(
    .ADDR_W     (ADDR_W),
    .IDSEL_BASE (IDSEL_BASE),
    .DEV_LSB    (FLD_DEV_LSB),
    .DEV_W      (FLD_DEV_W)
  ) u_rw (
    .fields     (req_addr[FLD_DEV_LSB+FLD_DEV_W-1:2]),
    .t0_addr    (t0_addr),
    .idsel_vld  (t0_idsel_vld),
    .idsel_line (t0_idsel_line)
  );

  always_comb begin
    claim_d     = req_valid && (route != ROUTE_NONE);
    type_d      = 1'b0;
    addr_d      = '0;
    idsel_vld_d = 1'b0;
    line_d      = '0;
    case (route)
      ROUTE_CONVERT: begin
        addr_d      = t0_addr;
        idsel_vld_d = t0_idsel_vld;
        line_d      = t0_idsel_line;
      end
      ROUTE_FORWARD: begin
        type_d = 1'b1;
        addr_d = req_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      claim_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
      claim_q <= claim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q      <= 1'b0;
      addr_q      <= '0;
      idsel_vld_q <= 1'b0;
      line_q      <= '0;
    end else if (req_valid) begin
      type_q      <= type_d;
      addr_q      <= addr_d;
      idsel_vld_q <= idsel_vld_d;
      line_q      <= line_d;
    end
  end

  assign rsp_valid      = valid_q;
  assign rsp_claim      = claim_q;
  assign rsp_type       = type_q;
  assign rsp_addr       = addr_q;
  assign rsp_idsel_vld  = idsel_vld_q;
  assign rsp_idsel_line = line_q;
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_claim,
  input logic              rsp_type,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_idsel_vld,
  input logic [LINE_W-1:0] rsp_idsel_line
);
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_VALID_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_claim); // R9
  AST_BAD_ENC_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b01) |=> !rsp_claim); // R3
  AST_T0_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_claim && !rsp_type) |-> (rsp_addr[1:0] == 2'b00 && rsp_addr[15:11] == 5'd0)); // R5
  AST_T0_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_claim && !rsp_type) |-> $onehot0(rsp_addr[ADDR_W-1:16])); // R5
  AST_IDSEL_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_claim && rsp_idsel_vld) |-> rsp_addr[16 + int'(rsp_idsel_line)]); // R5
  AST_T0_NO_LINE_HIGH_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_claim && !rsp_type && !rsp_idsel_vld) |-> (rsp_addr[ADDR_W-1:16] == '0)); // R6
  AST_T1_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_claim && rsp_type) |-> (rsp_addr == $past(req_addr))); // R7
  AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_claim) |-> (rsp_addr == '0 && !rsp_idsel_vld)); // R8
endmodule

bind cfg_route_decoder cfgr_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .rsp_valid      (rsp_valid),
  .rsp_claim      (rsp_claim),
  .rsp_type       (rsp_type),
  .rsp_addr       (rsp_addr),
  .rsp_idsel_vld  (rsp_idsel_vld),
  .rsp_idsel_line (rsp_idsel_line)
);

// File: tb/tb_cfg_route_decoder.sv
`timescale 1ns/1ps
module tb_cfg_route_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        rsp_valid, rsp_claim, rsp_type, rsp_idsel_vld;
  logic [31:0] rsp_addr;
  logic [3:0]  rsp_idsel_line;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_route_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
    .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_idsel_vld(rsp_idsel_vld),
    .rsp_idsel_line(rsp_idsel_line)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] bus, input logic [4:0] dev,
                                     input logic [2:0] fn, input logic [5:0] rg, input logic [1:0] enc);
    return {8'hA5, bus, dev, fn, rg, enc};
  endfunction

  task automatic wr(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ofs; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] ofs, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = ofs;
    #1 chk(req, "reg_rdata", 32'(reg_rdata), 32'(exp));
  endtask

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic claim, input logic typ,
                            input logic [31:0] addr, input logic iv, input logic [3:0] line);
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_claim", 32'(rsp_claim), 32'(claim));
    if (claim) chk(req, "rsp_type", 32'(rsp_type), 32'(typ));
    chk(req, "rsp_addr", rsp_addr, addr);
    chk(req, "rsp_idsel_vld", 32'(rsp_idsel_vld), 32'(iv));
    if (iv) chk(req, "rsp_idsel_line", 32'(rsp_idsel_line), 32'(line));
  endtask

  function automatic logic [31:0] t0(input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] rg);
    logic [31:0] a;
    a = {16'h0, 5'd0, fn, rg, 2'b00};
    if (dev < 16) a[16 + dev] = 1'b1;
    return a;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "rsp_claim", 32'(rsp_claim), 32'd0);
    rd("R1", 8'h18, 8'h00);
    rd("R1", 8'h19, 8'h00);
    rd("R1", 8'h1A, 8'h00);
  endtask

  task automatic t_regs();
    wr(8'h18, 8'h00); wr(8'h19, 8'h01); wr(8'h1A, 8'h05);
    rd("R2", 8'h18, 8'h00); rd("R2", 8'h19, 8'h01); rd("R2", 8'h1A, 8'h05);
    wr(8'h1B, 8'hAA); wr(8'h17, 8'h55);
    rd("R2", 8'h1B, 8'h00); rd("R2", 8'h17, 8'h00);
    rd("R2", 8'h19, 8'h01); rd("R2", 8'h1A, 8'h05);
    wr(8'h18, 8'h3C); rd("R2", 8'h18, 8'h3C);
  endtask

  task automatic t_convert();
    send(mk(8'h01, 5'd3, 3'd5, 6'h2A, 2'b01));
    expect_rsp("R4/R5", 1, 0, t0(5'd3, 3'd5, 6'h2A), 1, 4'd3);
    send(mk(8'h01, 5'd0, 3'd7, 6'h3F, 2'b01));
    expect_rsp("R5", 1, 0, t0(5'd0, 3'd7, 6'h3F), 1, 4'd0);
    send(mk(8'h01, 5'd15, 3'd1, 6'h01, 2'b01));
    expect_rsp("R5", 1, 0, t0(5'd15, 3'd1, 6'h01), 1, 4'd15);
  endtask

  task automatic t_dev_high();
    send(mk(8'h01, 5'd20, 3'd2, 6'h10, 2'b01));
    expect_rsp("R6", 1, 0, t0(5'd20, 3'd2, 6'h10), 0, 4'd0);
    send(mk(8'h01, 5'd16, 3'd0, 6'h00, 2'b01));
    expect_rsp("R6", 1, 0, 32'h0, 0, 4'd0);
  endtask

  task automatic t_forward();
    send(mk(8'h02, 5'd9, 3'd3, 6'h11, 2'b01));
    expect_rsp("R7", 1, 1, mk(8'h02, 5'd9, 3'd3, 6'h11, 2'b01), 0, 4'd0);
    send(mk(8'h05, 5'd31, 3'd7, 6'h3F, 2'b01));
    expect_rsp("R7", 1, 1, mk(8'h05, 5'd31, 3'd7, 6'h3F, 2'b01), 0, 4'd0);
  endtask

  task automatic t_outside();
    send(mk(8'h00, 5'd1, 3'd0, 6'h00, 2'b01));
    expect_rsp("R8", 0, 0, 32'h0, 0, 4'd0);
    send(mk(8'h06, 5'd1, 3'd0, 6'h00, 2'b01));
    expect_rsp("R8", 0, 0, 32'h0, 0, 4'd0);
    send(mk(8'hFF, 5'd1, 3'd0, 6'h00, 2'b01));
    expect_rsp("R8", 0, 0, 32'h0, 0, 4'd0);
  endtask

  task automatic t_encoding();
    send(mk(8'h01, 5'd3, 3'd0, 6'h00, 2'b00));
    expect_rsp("R3", 0, 0, 32'h0, 0, 4'd0);
    send(mk(8'h03, 5'd3, 3'd0, 6'h00, 2'b10));
    expect_rsp("R3", 0, 0, 32'h0, 0, 4'd0);
    send(mk(8'h01, 5'd3, 3'd0, 6'h00, 2'b11));
    expect_rsp("R3", 0, 0, 32'h0, 0, 4'd0);
  endtask

  task automatic t_timing();
    send(mk(8'h01, 5'd2, 3'd0, 6'h00, 2'b01));
    chk("R9", "rsp_valid pulse", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R9", "rsp_valid after", 32'(rsp_valid), 32'd0);
    chk("R9", "rsp_claim after", 32'(rsp_claim), 32'd0);
  endtask

  task automatic t_empty_range();
    wr(8'h19, 8'h05); wr(8'h1A, 8'h03);
    send(mk(8'h05, 5'd4, 3'd1, 6'h02, 2'b01));
    expect_rsp("R4", 1, 0, t0(5'd4, 3'd1, 6'h02), 1, 4'd4);
    send(mk(8'h04, 5'd4, 3'd1, 6'h02, 2'b01));
    expect_rsp("R8", 0, 0, 32'h0, 0, 4'd0);
    send(mk(8'h06, 5'd4, 3'd1, 6'h02, 2'b01));
    expect_rsp("R8", 0, 0, 32'h0, 0, 4'd0);
  endtask

  task automatic t_same_cycle();
    wr(8'h19, 8'h01); wr(8'h1A, 8'h05);
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(8'h07, 5'd0, 3'd0, 6'h00, 2'b01);
    reg_wr_en = 1'b1; reg_addr = 8'h1A; reg_wdata = 8'h07;
    @(negedge clk);
    req_valid = 1'b0; reg_wr_en = 1'b0;
    expect_rsp("R10", 0, 0, 32'h0, 0, 4'd0);
    send(mk(8'h07, 5'd0, 3'd0, 6'h00, 2'b01));
    expect_rsp("R10", 1, 1, mk(8'h07, 5'd0, 3'd0, 6'h00, 2'b01), 0, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_convert();
    t_dev_high();
    t_forward();
    t_outside();
    t_encoding();
    t_timing();
    t_empty_range();
    t_same_cycle();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule